// File: doc/BRIEF.md
# Adaptive Clock Skew Trim Controller

This block holds the delay setting for one programmable clock delay buffer in a skew-correcting clock tree. A phase detector compares this zone's clock with a neighbouring zone's clock and reports an early/late verdict as two digital lines. The controller moves the setting one step at a time to cancel the measured skew. It keeps doing so during normal operation, so slow drift from supply droop and temperature keeps being tracked. One zone of the tree is tagged as the reference zone and stays pinned at the middle setting. Every other zone aligns to it, directly or through intermediate zones.

The setting is stored as a 128-bit thermometer vector. This uses more flops than a 7-bit binary count, but a corrupted vector is easy to spot. A built-in consistency check flags any vector that is not a clean run of ones. A step rate divider filters detector dither. A signed firmware offset lets critical paths be favoured, and the sum is clamped before it drives the delay line. For manufacturing test the setting can be preloaded and adjustment frozen. A serial shift path lets the stored vector be read out and overwritten.

Top module: `deskew_trim_ctrl`

## Requirements
- R1: After reset the stored setting is 64 (thermometer bits 0..63 set, the rest clear), therm_err is 0, and trim_code equals 64 plus the offset, clamped.
- R2: On an update cycle in adjust mode, cmp_up alone raises the setting by one and cmp_down alone lowers it by one.
- R3: The setting saturates: a raise at 127 and a lower at 0 leave it unchanged.
- R4: On an update cycle with both cmp_up and cmp_down high, or both low, the setting holds.
- R5: In adjust mode a step counter runs. An update cycle occurs when the counter is at or above rate_div, and the counter then returns to 0. Otherwise it increments. With a constant rate_div of N and continuous adjust mode, the first update falls on the (N+1)th cycle and later ones every N+1 cycles. The counter is cleared whenever adjust mode is left.
- R6: While is_ref is high (and neither scan_shift nor tst_load is high), the setting is forced to 64 and the detector is ignored.
- R7: While freeze is high (and scan_shift, tst_load and is_ref are low), the setting does not change, whatever the detector reports.
- R8: A cycle with tst_load high (and scan_shift low) writes tst_value into the setting. This takes priority over is_ref and freeze.
- R9: trim_code equals the setting plus fw_offset, clamped to 0..127. fw_offset is 7-bit two's complement (-64..63).
- R10: Thermometer layout: setting k has bits 0..k-1 set. While scan_shift is high, the vector shifts one place toward bit 127 each cycle and scan_in enters bit 0. This overrides every other mode. scan_out always shows bit 127.
- R11: therm_err is high exactly when the vector is not a clean run of ones from bit 0. Equivalently, with an implied 1 below bit 0 and an implied 0 above bit 127, it counts more than one 1-to-0 boundary.
- R12: For any vector, including a corrupted one, the setting used for trim_code is the number of set bits, capped at 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_up | input | 1 | Detector: add delay to this zone |
| cmp_down | input | 1 | Detector: remove delay from this zone |
| is_ref | input | 1 | This zone is the reference zone |
| freeze | input | 1 | Suspend adjustment |
| rate_div | input | 8 | Update divider; one update per rate_div+1 cycles |
| fw_offset | input | 7 | Signed firmware offset |
| tst_load | input | 1 | Preload strobe |
| tst_value | input | 7 | Preload setting |
| scan_shift | input | 1 | Shift the thermometer vector |
| scan_in | input | 1 | Serial data into bit 0 |
| scan_out | output | 1 | Bit 127 of the vector |
| trim_code | output | 7 | Clamped code to the delay line |
| therm_err | output | 1 | Thermometer consistency error |

## Verification
The bench drives the setting into both rails and then keeps pushing. A design without saturation would wrap from 127 to 0, or from 0 to 127, and trim_code would jump by the full range. It offsets the setting past both ends. Without the clamp, a negative sum would turn into a large code, or a code above 127 would wrap to a small one. It checks the exact cycle of the first update after a divider restart. An off-by-one counter would step a cycle early or late, and a counter not cleared by freeze would step right after release. It also shifts a vector with a stray one into the store. A wrong transition count would leave therm_err low, and a wrong decode would report the position of the top one instead of the number of ones.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    // Action applied to the stored thermometer vector in one cycle
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_UP,
        ACT_DOWN,
        ACT_CENTRE,
        ACT_LOAD,
        ACT_SHIFT
    } trim_act_e;

endpackage

// File: rtl/deskew_rate_div.sv
// Update pacing: counts adjust-mode cycles and flags an update cycle.
module deskew_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             run,
    input  logic [DIV_W-1:0] cnt_q,
    input  logic [DIV_W-1:0] rate_div,
    output logic [DIV_W-1:0] cnt_d,
    output logic             tick
);

    always_comb begin
        tick  = run && (cnt_q >= rate_div);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/deskew_therm_next.sv
// Next-state of the thermometer vector for each action.
module deskew_therm_next
    import deskew_pkg::*;
#(
    parameter int TRIM_W = 7,
    parameter int LEVELS = 1 << TRIM_W
) (
    input  trim_act_e         act,
    input  logic [LEVELS-1:0] therm_q,
    input  logic [TRIM_W-1:0] load_code,
    input  logic              scan_in,
    output logic [LEVELS-1:0] therm_d
);

    localparam int CENTRE = LEVELS / 2;

    logic [LEVELS-1:0] load_vec;
    logic [LEVELS-1:0] centre_vec;

    // Binary to thermometer expansion for the preload and centre values
    generate
        for (genvar gi = 0; gi < LEVELS; gi++) begin : g_expand
            assign load_vec[gi]   = (TRIM_W'(gi) < load_code);
            assign centre_vec[gi] = (gi < CENTRE) ? 1'b1 : 1'b0;
        end
    endgenerate

    always_comb begin
        therm_d = therm_q;
        unique case (act)
            ACT_SHIFT:  therm_d = {therm_q[LEVELS-2:0], scan_in};
            ACT_LOAD:   therm_d = load_vec;
            ACT_CENTRE: therm_d = centre_vec;
            ACT_UP: begin
                // the top usable level is reached once bit LEVELS-2 is set
                if (!therm_q[LEVELS-2]) begin
                    therm_d = {therm_q[LEVELS-2:0], 1'b1};
                end
            end
            ACT_DOWN: begin
                if (therm_q[0]) begin
                    therm_d = {1'b0, therm_q[LEVELS-1:1]};
                end
            end
            default:    therm_d = therm_q;
        endcase
    end

endmodule

// File: rtl/deskew_therm_check.sv
// Decode of the thermometer vector and its consistency check.
module deskew_therm_check #(
    parameter int TRIM_W = 7,
    parameter int LEVELS = 1 << TRIM_W
) (
    input  logic [LEVELS-1:0] therm,
    output logic [TRIM_W-1:0] setting,
    output logic              multi_edge
);

    logic [TRIM_W:0] ones;
    logic            seen_one_edge;
    logic            seen_two_edges;
    logic            below;

    // Population count, capped at the top level
    always_comb begin
        ones = '0;
        for (int i = 0; i < LEVELS; i++) begin
            ones = ones + {{TRIM_W{1'b0}}, therm[i]};
        end
        if (ones[TRIM_W]) begin
            setting = '1;
        end else begin
            setting = ones[TRIM_W-1:0];
        end
    end

    // Count 1-to-0 boundaries walking up from an implied 1 below bit 0
    // to an implied 0 above the top bit; a clean vector has exactly one.
    always_comb begin
        seen_one_edge  = 1'b0;
        seen_two_edges = 1'b0;
        below          = 1'b1;
        for (int i = 0; i < LEVELS; i++) begin
            if (below && !therm[i]) begin
                seen_two_edges = seen_two_edges | seen_one_edge;
                seen_one_edge  = 1'b1;
            end
            below = therm[i];
        end
        if (below) begin
            seen_two_edges = seen_two_edges | seen_one_edge;
            seen_one_edge  = 1'b1;
        end
        multi_edge = seen_two_edges;
    end

endmodule

// File: rtl/deskew_trim_clamp.sv
// Adds the signed firmware offset and clamps to the delay line range.
module deskew_trim_clamp #(
    parameter int TRIM_W = 7,
    parameter int OFS_W  = 7
) (
    input  logic [TRIM_W-1:0]       setting,
    input  logic signed [OFS_W-1:0] offset,
    output logic [TRIM_W-1:0]       trim
);

    localparam int SUM_W = TRIM_W + 2;

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] ofs_ext;
    logic signed [SUM_W-1:0] top;

    always_comb begin
        ofs_ext = {{(SUM_W-OFS_W){offset[OFS_W-1]}}, offset};
        top     = $signed({2'b00, {TRIM_W{1'b1}}});
        sum     = $signed({2'b00, setting}) + ofs_ext;
        if (sum[SUM_W-1]) begin
            trim = '0;
        end else if (sum > top) begin
            trim = '1;
        end else begin
            trim = sum[TRIM_W-1:0];
        end
    end

endmodule

// File: rtl/deskew_trim_ctrl.sv
// Skew trim controller for one zone of a clock distribution tree.
module deskew_trim_ctrl
    import deskew_pkg::*;
#(
    parameter int TRIM_W = 7,
    parameter int DIV_W  = 8,
    parameter int OFS_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_up,
    input  logic                    cmp_down,
    input  logic                    is_ref,
    input  logic                    freeze,
    input  logic [DIV_W-1:0]        rate_div,
    input  logic signed [OFS_W-1:0] fw_offset,
    input  logic                    tst_load,
    input  logic [TRIM_W-1:0]       tst_value,
    input  logic                    scan_shift,
    input  logic                    scan_in,
    output logic                    scan_out,
    output logic [TRIM_W-1:0]       trim_code,
    output logic                    therm_err
);

    localparam int LEVELS = 1 << TRIM_W;
    localparam int CENTRE = LEVELS / 2;

    typedef struct packed {
        logic [LEVELS-1:0] therm;
        logic [DIV_W-1:0]  cnt;
    } trim_state_t;

    trim_state_t st_d, st_q;

    logic              run;
    logic              step_tick;
    logic [DIV_W-1:0]  cnt_nx;
    logic [LEVELS-1:0] therm_nx;
    logic [LEVELS-1:0] therm_cur;
    logic [TRIM_W-1:0] setting;
    trim_act_e         act;

    assign therm_cur = st_q.therm;
    assign run       = !scan_shift && !tst_load && !is_ref && !freeze;

    deskew_rate_div #(.DIV_W(DIV_W)) rate_i (
        .run      (run),
        .cnt_q    (st_q.cnt),
        .rate_div (rate_div),
        .cnt_d    (cnt_nx),
        .tick     (step_tick)
    );

    // Mode priority: shift, preload, reference, freeze, then tracking
    always_comb begin
        act = ACT_HOLD;
        if (scan_shift) begin
            act = ACT_SHIFT;
        end else if (tst_load) begin
            act = ACT_LOAD;
        end else if (is_ref) begin
            act = ACT_CENTRE;
        end else if (freeze) begin
            act = ACT_HOLD;
        end else if (step_tick && (cmp_up ^ cmp_down)) begin
            act = cmp_up ? ACT_UP : ACT_DOWN;
        end
    end

    deskew_therm_next #(.TRIM_W(TRIM_W), .LEVELS(LEVELS)) next_i (
        .act       (act),
        .therm_q   (st_q.therm),
        .load_code (tst_value),
        .scan_in   (scan_in),
        .therm_d   (therm_nx)
    );

    deskew_therm_check #(.TRIM_W(TRIM_W), .LEVELS(LEVELS)) check_i (
        .therm      (st_q.therm),
        .setting    (setting),
        .multi_edge (therm_err)
    );

    deskew_trim_clamp #(.TRIM_W(TRIM_W), .OFS_W(OFS_W)) clamp_i (
        .setting (setting),
        .offset  (fw_offset),
        .trim    (trim_code)
    );

    always_comb begin
        st_d       = st_q;
        st_d.therm = therm_nx;
        st_d.cnt   = cnt_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.therm <= LEVELS'((LEVELS'(1) << CENTRE) - LEVELS'(1));
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_out = st_q.therm[LEVELS-1];

endmodule

// File: rtl/deskew_trim_chk.sv
// Temporal checks for the trim controller, bound into every instance.
module deskew_trim_chk #(
    parameter int TRIM_W = 7,
    parameter int DIV_W  = 8,
    parameter int OFS_W  = 7,
    parameter int LEVELS = 1 << TRIM_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmp_up,
    input logic                    cmp_down,
    input logic                    is_ref,
    input logic                    freeze,
    input logic                    tst_load,
    input logic [TRIM_W-1:0]       tst_value,
    input logic                    scan_shift,
    input logic                    scan_in,
    input logic signed [OFS_W-1:0] fw_offset,
    input logic [TRIM_W-1:0]       trim_code,
    input logic                    therm_err,
    input logic [LEVELS-1:0]       therm_cur,
    input logic [TRIM_W-1:0]       setting,
    input logic                    step_tick
);

    localparam int CENTRE = LEVELS / 2;

    logic tracking;
    assign tracking = !scan_shift && !tst_load && !is_ref && !freeze;

    p_ref_centre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && !scan_shift && !tst_load) |=> (int'(setting) == CENTRE));

    p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !is_ref && !scan_shift && !tst_load) |=> (therm_cur == $past(therm_cur)));

    p_both_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && cmp_up && cmp_down) |=> (therm_cur == $past(therm_cur)));

    p_preload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_load && !scan_shift) |=> (setting == $past(tst_value)));

    p_paced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && !step_tick) |=> (therm_cur == $past(therm_cur)));

    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && !therm_err) |=>
            ((int'(setting) <= int'($past(setting)) + 1) &&
             (int'(setting) + 1 >= int'($past(setting)))));

    p_shift_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_shift |=> (therm_cur[0] == $past(scan_in)));

    p_no_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_offset == '0) |-> (trim_code == setting));

endmodule

bind deskew_trim_ctrl deskew_trim_chk #(
    .TRIM_W (TRIM_W),
    .DIV_W  (DIV_W),
    .OFS_W  (OFS_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_up     (cmp_up),
    .cmp_down   (cmp_down),
    .is_ref     (is_ref),
    .freeze     (freeze),
    .tst_load   (tst_load),
    .tst_value  (tst_value),
    .scan_shift (scan_shift),
    .scan_in    (scan_in),
    .fw_offset  (fw_offset),
    .trim_code  (trim_code),
    .therm_err  (therm_err),
    .therm_cur  (therm_cur),
    .setting    (setting),
    .step_tick  (step_tick)
);

// File: tb/deskew_trim_ctrl_tb_top.sv
module deskew_trim_ctrl_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_up = 1'b0;
    logic              cmp_down = 1'b0;
    logic              is_ref = 1'b0;
    logic              freeze = 1'b0;
    logic [7:0]        rate_div = 8'd0;
    logic signed [6:0] fw_offset = 7'sd0;
    logic              tst_load = 1'b0;
    logic [6:0]        tst_value = 7'd0;
    logic              scan_shift = 1'b0;
    logic              scan_in = 1'b0;
    logic              scan_out;
    logic [6:0]        trim_code;
    logic              therm_err;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [127:0] m_vec;
    int           m_cnt;

    always #2.5 clk = ~clk;

    deskew_trim_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_up(cmp_up), .cmp_down(cmp_down),
        .is_ref(is_ref), .freeze(freeze), .rate_div(rate_div),
        .fw_offset(fw_offset), .tst_load(tst_load), .tst_value(tst_value),
        .scan_shift(scan_shift), .scan_in(scan_in), .scan_out(scan_out),
        .trim_code(trim_code), .therm_err(therm_err)
    );

    function automatic int ones_of(input logic [127:0] v);
        int n = 0;
        for (int i = 0; i < 128; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [127:0] thermo(input int k);
        logic [127:0] v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic int exp_trim(input logic [127:0] v, input int ofs);
        int s = ones_of(v);
        if (s > 127) s = 127;
        s = s + ofs;
        if (s < 0) s = 0;
        if (s > 127) s = 127;
        return s;
    endfunction

    function automatic int exp_err(input logic [127:0] v);
        return (v != thermo(ones_of(v))) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "trim_code", int'(trim_code), exp_trim(m_vec, int'(fw_offset)));
        chk(tag, "therm_err", int'(therm_err), exp_err(m_vec));
        chk(tag, "scan_out", int'(scan_out), int'(m_vec[127]));
    endtask

    // Model of one clock edge, from the requirements
    task automatic model_update();
        int s = ones_of(m_vec);
        if (scan_shift) begin
            m_vec = {m_vec[126:0], scan_in}; m_cnt = 0;
        end else if (tst_load) begin
            m_vec = thermo(int'(tst_value)); m_cnt = 0;
        end else if (is_ref) begin
            m_vec = thermo(64); m_cnt = 0;
        end else if (freeze) begin
            m_cnt = 0;
        end else if (m_cnt >= int'(rate_div)) begin
            m_cnt = 0;
            if (cmp_up && !cmp_down && s < 127) m_vec = (m_vec << 1) | 128'd1;
            if (cmp_down && !cmp_up && s > 0)   m_vec = m_vec >> 1;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic cyc(input string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic preload(input int v);
        tst_load = 1'b1; tst_value = 7'(v);
        cyc("R8");
        tst_load = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        m_vec = thermo(64);
        m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        chk("R1", "reset trim", int'(trim_code), 64);
        chk("R1", "reset err", int'(therm_err), 0);

        // R2/R3: drive to top rail and beyond
        cmp_up = 1'b1;
        cyc("R2");
        chk("R2", "one step up", int'(trim_code), 65);
        cycles(70, "R3");
        chk("R3", "high rail", int'(trim_code), 127);
        // R4: both asserted holds
        cmp_down = 1'b1;
        cycles(5, "R4");
        chk("R4", "both hold", int'(trim_code), 127);
        cmp_up = 1'b0;
        cyc("R2");
        chk("R2", "one step down", int'(trim_code), 126);
        cycles(140, "R3");
        chk("R3", "low rail", int'(trim_code), 0);
        cmp_down = 1'b0;
        cycles(3, "R4");
        chk("R4", "idle hold", int'(trim_code), 0);

        // R6: reference zone pinned at centre despite detector
        is_ref = 1'b1; cmp_down = 1'b1;
        cycles(4, "R6");
        chk("R6", "centre", int'(trim_code), 64);
        is_ref = 1'b0; cmp_down = 1'b0;

        // R5: divider pacing
        preload(64);
        rate_div = 8'd3; cmp_up = 1'b1;
        cycles(3, "R5");
        chk("R5", "before first update", int'(trim_code), 64);
        cyc("R5");
        chk("R5", "first update", int'(trim_code), 65);
        cycles(4, "R5");
        chk("R5", "second update", int'(trim_code), 66);
        cycles(2, "R5");
        // R7: freeze holds and restarts the divider
        freeze = 1'b1;
        cycles(10, "R7");
        chk("R7", "frozen", int'(trim_code), 66);
        freeze = 1'b0;
        cycles(3, "R7");
        chk("R7", "restart no early step", int'(trim_code), 66);
        cyc("R7");
        chk("R7", "restart step", int'(trim_code), 67);
        cmp_up = 1'b0; rate_div = 8'd0;

        // R8: preload beats reference and freeze
        is_ref = 1'b1; freeze = 1'b1;
        preload(10);
        chk("R8", "preload wins", int'(trim_code), 10);
        is_ref = 1'b0;

        // R9: offset and clamping
        fw_offset = -7'sd5;
        cyc("R9");
        chk("R9", "offset minus", int'(trim_code), 5);
        fw_offset = -7'sd64;
        cyc("R9");
        chk("R9", "clamp low", int'(trim_code), 0);
        preload(120);
        fw_offset = 7'sd63;
        cyc("R9");
        chk("R9", "clamp high", int'(trim_code), 127);
        fw_offset = 7'sd0;

        // R10/R11/R12: shift a corrupted vector in, MSB first
        preload(20);
        begin
            logic [127:0] pat;
            pat = thermo(20);
            pat[50] = 1'b1;
            scan_shift = 1'b1;
            for (int i = 127; i >= 0; i--) begin
                scan_in = pat[i];
                cyc("R10");
            end
            scan_shift = 1'b0;
            scan_in = 1'b0;
            cyc("R11");
            chk("R11", "corrupt flagged", int'(therm_err), 1);
            chk("R12", "corrupt decode", int'(trim_code), 21);
        end
        // all ones is a clean run: decode caps at 127
        scan_shift = 1'b1; scan_in = 1'b1;
        cycles(128, "R10");
        scan_shift = 1'b0; scan_in = 1'b0;
        cyc("R12");
        chk("R12", "all ones cap", int'(trim_code), 127);
        chk("R11", "all ones clean", int'(therm_err), 0);
        preload(64);
        freeze = 1'b0;

        // Constrained random tracking phase
        for (int n = 0; n < 4000; n++) begin
            cmp_up   = ($urandom % 2) == 1;
            cmp_down = ($urandom % 2) == 1;
            freeze   = ($urandom % 20) == 0;
            is_ref   = ($urandom % 40) == 0;
            tst_load = ($urandom % 50) == 0;
            tst_value = 7'($urandom % 128);
            if (($urandom % 200) == 0) rate_div = 8'($urandom % 4);
            if (($urandom % 25) == 0)  fw_offset = 7'($urandom % 128);
            cyc("R2");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule